// File: doc/BRIEF.md
# Serial NOR Flash Image Writer

This block copies a byte stream of known length into a serial NOR flash, starting at flash address zero and using single-bit SPI (mode 0). A pulse on `start_i` captures the image length. The block then works through a fixed loop until the image is stored. It enables writes, erases a block, and waits for the flash to go idle. Then it enables writes again, programs one page, and waits again. It starts a new erase only when the page address crosses the boundary of the block it erased last.

Image bytes come in over a valid/ready handshake, one byte per accepted transfer, with no page buffer. If the source runs dry in the middle of a page, SCK stays low and the page frame stays open until data returns. Images shorter than a minimum size are extended with zero bytes, and a short final page is padded with zeros. The handshake is never asserted for the padding. When the busy flag clears after the last page, `done_o` pulses for one cycle so the surrounding system can reset.

The sizes of a page, of the small and large erase blocks, and of the minimum image are parameters. Their defaults are 256, 4096, 65536 and 1024 bytes.

Top module: `flash_image_writer`

## Requirements
- R1: After reset and while idle, `cs_n_o` is 1, `sck_o` is 0, and `done_o` and `src_ready_o` are 0.
- R2: SPI mode 0. SCK is high only while CS is low, and each high phase lasts exactly one clock. MOSI does not change while SCK is high. Every frame carries whole bytes, each sent MSB first.
- R3: Before every erase and before every page program, a frame holding only the byte 0x06 is sent on its own.
- R4: An erase frame is 4 bytes: the opcode, then address bits 23:16, 15:8 and 7:0. The opcode is 0xD8 (large block) when at least BIG_BLK bytes remain, and 0x20 (small block) otherwise.
- R5: A program frame is 0x02, then the 3 address bytes, then exactly PAGE_BYTES data bytes in image order.
- R6: After every erase and every program, 2-byte frames starting with 0x05 repeat until bit 0 of the second byte received on MISO reads 0. No other status bit affects the decision.
- R7: After each page, the address advances by PAGE_BYTES and the remaining count drops by PAGE_BYTES. If the new address is a multiple of the size of the block erased last, a new erase follows; otherwise the next page is programmed.
- R8: Image positions at or beyond the length are sent as 0x00. The image is treated as at least MIN_IMAGE bytes. `src_ready_o` is asserted only for positions below the length, so exactly the stated number of bytes is taken.
- R9: While the source is not valid during a page, SCK stays low and the frame stays open. The page continues when data returns.
- R10: Once the remaining count is at most PAGE_BYTES and the final poll shows idle, `done_o` is high for exactly one cycle and no further frame follows. `start_i` is ignored while a run is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begins a run; only acted on while idle |
| len_i | input | LEN_W | Image length in bytes, captured with start |
| src_valid_i | input | 1 | Image byte on src_data_i is valid |
| src_data_i | input | 8 | Next image byte |
| src_ready_o | output | 1 | Block takes the byte this cycle if valid |
| sck_o | output | 1 | SPI clock, idle low |
| cs_n_o | output | 1 | SPI chip select, active low |
| mosi_o | output | 1 | SPI data to flash |
| miso_i | input | 1 | SPI data from flash |
| done_o | output | 1 | One-cycle pulse when the image is stored |

## Verification
CS falls one clock after a frame is opened, and the first SCK high phase comes two clocks after that. Each bit is therefore judged at the single clock in which SCK is high. The bench flash model captures MOSI there and drives the status reply on MISO half a cycle before the clock edge that ends that phase. A finished frame is compared against the next expected entry in the cycle in which CS returns high. `done_o` rises in that same cycle after the last clean poll, so the done check runs in the same sampling slot, after the frame comparison. A source byte counts as taken when valid and ready are both high half a cycle before an edge. The stall check reads SCK in every such waiting cycle.

// File: rtl/fiw_pkg.sv
`timescale 1ns/1ps
package fiw_pkg;
  localparam int FLASH_ADDR_W = 24;

  localparam logic [7:0] OPC_WR_ENABLE  = 8'h06;
  localparam logic [7:0] OPC_ERASE_SML  = 8'h20;
  localparam logic [7:0] OPC_ERASE_BIG  = 8'hD8;
  localparam logic [7:0] OPC_PAGE_WRITE = 8'h02;
  localparam logic [7:0] OPC_GET_STATUS = 8'h05;

  typedef enum logic [1:0] {FR_WREN, FR_ERASE, FR_PROG, FR_POLL} frame_kind_e;
  typedef enum logic [1:0] {PH_IDLE, PH_GAP, PH_XFER, PH_FINISH} phase_e;
endpackage

// File: rtl/fiw_shift.sv
`timescale 1ns/1ps
// Byte serializer: two clocks per bit, SCK low then high, MISO taken as the high phase ends.
module fiw_shift (
  input  logic       clk,
  input  logic       rst,
  input  logic       go,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       done,
  output logic       rx_lsb
);
  logic [7:0] sh;
  logic [2:0] cnt;
  logic       active;
  logic       high;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh <= '0; cnt <= '0; active <= 1'b0; high <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (go) begin
          active <= 1'b1;
          high   <= 1'b0;
          cnt    <= '0;
          sh     <= tx;
        end
      end else if (!high) begin
        high <= 1'b1;
      end else begin
        high <= 1'b0;
        sh   <= {sh[6:0], miso};
        cnt  <= cnt + 3'd1;
        if (cnt == 3'd7) begin
          active <= 1'b0;
          done   <= 1'b1;
        end
      end
    end
  end

  assign sck    = high;
  assign mosi   = sh[7];
  assign rx_lsb = sh[0];
endmodule

// File: rtl/fiw_frame_fmt.sv
`timescale 1ns/1ps
// Chooses the byte to send at a given frame position and reports the frame's last index.
module fiw_frame_fmt
  import fiw_pkg::*;
#(
  parameter int unsigned PAGE_BYTES = 256,
  parameter int unsigned IDX_W      = 9
) (
  input  frame_kind_e               kind,
  input  logic [IDX_W-1:0]          bidx,
  input  logic [FLASH_ADDR_W-1:0]   addr,
  input  logic                      big,
  input  logic [7:0]                data,
  output logic [7:0]                tx,
  output logic [IDX_W-1:0]          last
);
  logic [7:0] opc;

  always_comb begin
    case (kind)
      FR_WREN:  begin opc = OPC_WR_ENABLE;  last = '0; end
      FR_POLL:  begin opc = OPC_GET_STATUS; last = IDX_W'(1); end
      FR_ERASE: begin opc = big ? OPC_ERASE_BIG : OPC_ERASE_SML; last = IDX_W'(3); end
      default:  begin opc = OPC_PAGE_WRITE; last = IDX_W'(PAGE_BYTES + 3); end
    endcase
  end

  always_comb begin
    case (bidx)
      IDX_W'(0): tx = opc;
      IDX_W'(1): tx = (kind == FR_POLL) ? 8'h00 : addr[23:16];
      IDX_W'(2): tx = addr[15:8];
      IDX_W'(3): tx = addr[7:0];
      default:   tx = data;
    endcase
  end
endmodule

// File: rtl/flash_image_writer.sv
`timescale 1ns/1ps
module flash_image_writer
  import fiw_pkg::*;
#(
  parameter int unsigned PAGE_BYTES = 256,
  parameter int unsigned SMALL_BLK  = 4096,
  parameter int unsigned BIG_BLK    = 65536,
  parameter int unsigned MIN_IMAGE  = 1024,
  parameter int unsigned LEN_W      = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             src_valid_i,
  input  logic [7:0]       src_data_i,
  output logic             src_ready_o,
  output logic             sck_o,
  output logic             cs_n_o,
  output logic             mosi_o,
  input  logic             miso_i,
  output logic             done_o
);
  localparam int unsigned IDX_W = $clog2(PAGE_BYTES + 4);
  localparam int unsigned AW    = FLASH_ADDR_W;

  phase_e           phase;
  frame_kind_e      kind;
  logic [IDX_W-1:0] bidx, last_idx;
  logic             pend, big, after_prog, wren_to_prog;
  logic [AW-1:0]    addr;
  logic [LEN_W-1:0] rem, len_q;
  logic             cs_q, done_q;

  logic             go, byte_done, rx_lsb;
  logic [7:0]       tx_byte, data_byte;
  logic [AW-1:0]    img_pos, next_addr, blk_mask;
  logic             in_data, in_image, can_issue;

  assign img_pos   = addr + AW'(bidx) - AW'(4);
  assign in_data   = (phase == PH_XFER) && (kind == FR_PROG) && (bidx >= IDX_W'(4));
  assign in_image  = 32'(img_pos) < 32'(len_q);
  assign can_issue = (phase == PH_XFER) && !pend;
  assign go        = can_issue && (!(in_data && in_image) || src_valid_i);
  assign data_byte = in_image ? src_data_i : 8'h00;
  assign next_addr = addr + AW'(PAGE_BYTES);
  assign blk_mask  = big ? AW'(BIG_BLK - 1) : AW'(SMALL_BLK - 1);

  fiw_frame_fmt #(.PAGE_BYTES(PAGE_BYTES), .IDX_W(IDX_W)) u_fmt (
    .kind(kind), .bidx(bidx), .addr(addr), .big(big), .data(data_byte),
    .tx(tx_byte), .last(last_idx)
  );

  fiw_shift u_shift (
    .clk(clk), .rst(rst), .go(go), .tx(tx_byte), .miso(miso_i),
    .sck(sck_o), .mosi(mosi_o), .done(byte_done), .rx_lsb(rx_lsb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE; kind <= FR_WREN; bidx <= '0; pend <= 1'b0;
      big <= 1'b0; after_prog <= 1'b0; wren_to_prog <= 1'b0;
      addr <= '0; rem <= '0; len_q <= '0; cs_q <= 1'b1; done_q <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: if (start_i) begin
          len_q        <= len_i;
          rem          <= (32'(len_i) < MIN_IMAGE) ? LEN_W'(MIN_IMAGE) : len_i;
          addr         <= '0;
          kind         <= FR_WREN;
          wren_to_prog <= 1'b0;
          bidx         <= '0;
          phase        <= PH_GAP;
        end
        PH_GAP: begin
          phase <= PH_XFER;
          cs_q  <= 1'b0;
        end
        PH_XFER: begin
          if (go) pend <= 1'b1;
          if (byte_done) begin
            pend <= 1'b0;
            if (bidx != last_idx) begin
              bidx <= bidx + IDX_W'(1);
            end else begin
              bidx  <= '0;
              cs_q  <= 1'b1;
              phase <= PH_GAP;
              case (kind)
                FR_WREN: begin
                  kind <= wren_to_prog ? FR_PROG : FR_ERASE;
                  if (!wren_to_prog) big <= 32'(rem) >= BIG_BLK;
                end
                FR_ERASE: begin kind <= FR_POLL; after_prog <= 1'b0; end
                FR_PROG:  begin kind <= FR_POLL; after_prog <= 1'b1; end
                default: begin
                  if (rx_lsb) begin
                    kind <= FR_POLL;
                  end else if (!after_prog) begin
                    kind <= FR_WREN; wren_to_prog <= 1'b1;
                  end else if (32'(rem) <= PAGE_BYTES) begin
                    phase  <= PH_FINISH;
                    done_q <= 1'b1;
                  end else begin
                    rem          <= rem - LEN_W'(PAGE_BYTES);
                    addr         <= next_addr;
                    kind         <= FR_WREN;
                    wren_to_prog <= (next_addr & blk_mask) != '0;
                  end
                end
              endcase
            end
          end
        end
        default: begin
          done_q <= 1'b0;
          phase  <= PH_IDLE;
        end
      endcase
    end
  end

  assign src_ready_o = can_issue && in_data && in_image;
  assign cs_n_o      = cs_q;
  assign done_o      = done_q;
endmodule

// File: rtl/fiw_checks.sv
`timescale 1ns/1ps
module fiw_checks (
  input logic clk,
  input logic rst,
  input logic cs_n,
  input logic sck,
  input logic mosi,
  input logic done,
  input logic ready
);
  assert_sck_framed_R2: assert property (@(posedge clk) disable iff (rst) sck |-> !cs_n)
    else $error("SCK high outside a frame");
  assert_sck_single_high_R2: assert property (@(posedge clk) disable iff (rst) sck |=> !sck)
    else $error("SCK high for more than one clock");
  assert_mosi_hold_R2: assert property (@(posedge clk) disable iff (rst) sck |-> $stable(mosi))
    else $error("MOSI moved while SCK high");
  assert_stall_sck_low_R9: assert property (@(posedge clk) disable iff (rst) ready |-> (!sck && !cs_n))
    else $error("SCK not parked low while waiting for data");
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst) done |=> !done)
    else $error("done wider than one cycle");
  assert_done_deselect_R10: assert property (@(posedge clk) disable iff (rst) done |-> (cs_n && !sck))
    else $error("done raised inside a frame");
endmodule

bind flash_image_writer fiw_checks u_checks (
  .clk(clk), .rst(rst), .cs_n(cs_n_o), .sck(sck_o), .mosi(mosi_o),
  .done(done_o), .ready(src_ready_o)
);

// File: tb/flash_image_writer_test.sv
`timescale 1ns/1ps
module flash_image_writer_test;
  localparam int PAGE = 16, SMALL = 64, BIG = 256, MINI = 64, LW = 16;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [LW-1:0] img_len = '0;
  logic src_valid = 1'b0, src_ready;
  logic [7:0] src_data = 8'h00;
  logic sck, cs_n, mosi, miso = 1'b0, done;

  flash_image_writer #(.PAGE_BYTES(PAGE), .SMALL_BLK(SMALL), .BIG_BLK(BIG),
                       .MIN_IMAGE(MINI), .LEN_W(LW)) uut (
    .clk(clk), .rst(rst), .start_i(start), .len_i(img_len),
    .src_valid_i(src_valid), .src_data_i(src_data), .src_ready_o(src_ready),
    .sck_o(sck), .cs_n_o(cs_n), .mosi_o(mosi), .miso_i(miso), .done_o(done)
  );

  always #10 clk = ~clk;

  typedef struct { logic [7:0] op; int n; int addr; int hash; } frame_t;
  frame_t exp_q[$];

  int nchk = 0, nfail = 0;
  int cur_len = 0, src_idx = 0, cyc = 0, stall_cyc = 0, stall_bad = 0;
  bit stall_mode = 0, take = 0;
  int done_cnt = 0, clk_bad = 0, busy_left = 0;
  int nbits, nbytes, faddr, fhash;
  logic [7:0] fop, cur;
  bit prev_cs = 1, prev_sck = 0, prev_mosi = 0, prev_done = 0;

  function automatic logic [7:0] pat(int i);
    return 8'((i * 13) + 5);
  endfunction

  function automatic string tag_of(logic [7:0] op);
    case (op)
      8'h06: return "R3 write-enable frame";
      8'h02: return "R5 page frame";
      8'h05: return "R6 status frame";
      default: return "R4 erase frame";
    endcase
  endfunction

  task automatic chk(bit ok, string what, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic push(logic [7:0] op, int n, int addr, int hash);
    frame_t f;
    f.op = op; f.n = n; f.addr = addr; f.hash = hash;
    exp_q.push_back(f);
  endtask

  // Driver side of the scoreboard: expected frames derived from the requirements.
  task automatic build_expected(int len);
    int rem, addr, mask, h;
    bit big, fin, nxt_erase;
    rem = (len < MINI) ? MINI : len;
    addr = 0; fin = 0;
    while (!fin) begin
      big = rem >= BIG;
      mask = big ? BIG - 1 : SMALL - 1;
      push(8'h06, 1, 0, 0);
      push(big ? 8'hD8 : 8'h20, 4, addr, 0);
      for (int p = 0; p < 3; p++) push(8'h05, 2, 0, 0);
      nxt_erase = 0;
      while (!fin && !nxt_erase) begin
        h = 0;
        for (int i = 0; i < PAGE; i++)
          h = h * 31 + int'((addr + i < len) ? pat(addr + i) : 8'h00);
        push(8'h06, 1, 0, 0);
        push(8'h02, 4 + PAGE, addr, h);
        for (int p = 0; p < 2; p++) push(8'h05, 2, 0, 0);
        if (rem <= PAGE) fin = 1;
        else begin
          rem -= PAGE; addr += PAGE;
          nxt_erase = (addr & mask) == 0;
        end
      end
    end
  endtask

  task automatic end_frame();
    frame_t e;
    chk(nbits % 8 == 0, "R2 whole bytes per frame", nbits, (nbits / 8) * 8);
    if (exp_q.size() == 0) begin
      chk(0, "R10 frame after completion", int'(fop), 0);
    end else begin
      e = exp_q.pop_front();
      chk(fop == e.op, tag_of(e.op), int'(fop), int'(e.op));
      chk(nbytes == e.n, tag_of(e.op), nbytes, e.n);
      if (e.n >= 4) chk(faddr == e.addr, "R7 frame address", faddr, e.addr);
      if (e.n > 4)  chk(fhash == e.hash, "R8 page contents with zero fill", fhash, e.hash);
    end
    if (fop == 8'h20 || fop == 8'hD8) busy_left = 2;
    else if (fop == 8'h02) busy_left = 1;
    else if (fop == 8'h05 && busy_left > 0) busy_left--;
  endtask

  // Flash model and monitor: decodes frames, answers status polls, pops the scoreboard.
  initial begin
    logic [7:0] stat;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (cs_n && sck) clk_bad++;
        if (!cs_n) begin
          if (prev_cs) begin nbits = 0; nbytes = 0; fop = 0; faddr = 0; fhash = 0; cur = 0; end
          if (sck && prev_sck) clk_bad++;
          if (sck && mosi != prev_mosi) clk_bad++;
          if (sck && !prev_sck) begin
            stat = (busy_left > 0) ? 8'h01 : 8'hFE;
            miso = (nbytes == 1 && fop == 8'h05) ? stat[7 - (nbits % 8)] : 1'b0;
            cur = {cur[6:0], mosi};
            nbits++;
            if (nbits % 8 == 0) begin
              if (nbytes == 0) fop = cur;
              else if (nbytes <= 3) faddr = (faddr << 8) | int'(cur);
              else fhash = fhash * 31 + int'(cur);
              nbytes++;
            end
          end
        end else if (!prev_cs) begin
          end_frame();
        end
        if (done) begin
          done_cnt++;
          chk(exp_q.size() == 0, "R10 done after the final poll", exp_q.size(), 0);
          chk(!prev_done, "R10 done one cycle", 1, 0);
        end
      end
      prev_cs = cs_n; prev_sck = sck; prev_mosi = mosi; prev_done = done;
    end
  end

  // Byte source with optional stall pattern.
  initial begin
    forever begin
      @(negedge clk);
      if (take) src_idx++;
      cyc++;
      src_valid = (src_idx < cur_len) && !(stall_mode && (cyc % 7) < 3);
      src_data  = pat(src_idx);
      take      = src_valid && src_ready;
      if (src_ready && !src_valid) begin
        stall_cyc++;
        if (sck) stall_bad++;
      end
    end
  end

  task automatic finish_sim();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  task automatic run_image(int len, bit stall, bit stray);
    build_expected(len);
    stall_mode = stall; done_cnt = 0; src_idx = 0; cur_len = len;
    stall_cyc = 0; stall_bad = 0; clk_bad = 0;
    @(negedge clk); img_len = LW'(len); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (stray) begin
      repeat (500) @(negedge clk);
      img_len = LW'(5); start = 1'b1;   // R10: must be ignored mid-run
      @(negedge clk); start = 1'b0;
    end
    while (done_cnt == 0) @(negedge clk);
    repeat (30) @(negedge clk);
    chk(done_cnt == 1, "R10 single completion pulse", done_cnt, 1);
    chk(exp_q.size() == 0, "R10 all expected frames seen", exp_q.size(), 0);
    chk(src_idx == len, "R8 bytes taken from source", src_idx, len);
    chk(clk_bad == 0, "R2 mode-0 clocking", clk_bad, 0);
    chk(cs_n && !sck && !src_ready, "R1 idle after run", {cs_n, sck, src_ready}, 3'b100);
    if (stall) chk(stall_cyc > 0 && stall_bad == 0, "R9 SCK parked low during stall", stall_bad, 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "R10 watchdog expired", 0, 1);
    finish_sim();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cs_n == 1'b1, "R1 chip select after reset", cs_n, 1);
    chk(sck == 1'b0, "R1 clock after reset", sck, 0);
    chk(done == 1'b0 && src_ready == 1'b0, "R1 done and ready after reset", {done, src_ready}, 0);
    run_image(0, 0, 0);     // all padding, small erase (R8)
    run_image(150, 1, 0);   // small-block re-erase at boundaries, stalls (R7, R9)
    run_image(300, 0, 1);   // large erase then small, partial last page, stray start (R4, R10)
    run_image(64, 0, 0);    // exact minimum length
    finish_sim();
  end
endmodule